// File: doc/BRIEF.md
# Fully Connected Layer with One Shared Sigmoid

This block computes one fully connected neural-network layer of `NEUR` neurons over `FEAT` input features. A start pulse arms the layer. The features then arrive one per clock on a serial stream with a valid flag. Every neuron has its own multiply-accumulate unit, and all of them take the same feature on the same clock. Each unit starts from its neuron's bias and adds the product of that feature with its own weight. The weights and biases are held on wide static input buses, loaded before the run.

When the last feature has been accumulated, every sum is narrowed to the 9-bit signed data format. All of them are captured together into a parallel-in serial-out register. That register then shifts the values one per clock into a single sigmoid lookup table, which all neurons share. The table output is a serial stream of activations with a valid flag, in the same format as the input features, so it can feed a following layer of the same kind. A one-clock done pulse closes each run.

Data use 9-bit two's complement with 7 fraction bits, covering -2.0 up to just below 2.0. The sigmoid table is computed inside the RTL from a fifth-order series for the exponential.

Top module: `fc_serial_layer`

## Requirements
- R1: After reset, `actValid` and `layerDone` are low and stay low until a run is started.
- R2: A `layerInit` pulse seen while idle starts a run. From the next cycle on, the layer takes exactly `FEAT` features, one on each cycle where `featValid` is high, and ignores cycles where it is low. Neuron n's sum is bias_n*128 plus the sum over j of w[n][j]*x_j. Here x_j is the j-th accepted feature, w[n][j] sits at bit offset (n*FEAT+j)*9 of `weights`, and bias_n sits at bit offset n*9 of `biases`. All values are 9-bit two's complement.
- R3: Each sum is arithmetically shifted right by 7 and then saturated to the range -256..255 before activation.
- R4: Each output is within one LSB of round(128*s). For a narrowed value a and z = a/128, s = e/(1+e) when z is 0 or above and s = 1/(1+e) when z is below 0. Here e = 1+|z|+|z|^2/2+|z|^3/6+|z|^4/24+|z|^5/120.
- R5: A run emits exactly `NEUR` outputs on consecutive cycles, neuron 0 first, in ascending neuron index order.
- R6: When the features arrive on back-to-back cycles, the first being sampled on the clock edge after the start edge, the first output is valid after clock edge FEAT+2 counted from the start edge.
- R7: `layerDone` is high for exactly one cycle per run, in the cycle right after the last valid output.
- R8: A `layerInit` pulse during a run has no effect, and neither does `featValid` after the `FEAT`-th feature. The run's outputs, their timing and its single done pulse are unchanged.
- R9: Once a run's done pulse has been seen, a new `layerInit` starts a fresh run whose results depend only on its own features.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| layerInit | input | 1 | Start pulse, taken only while idle |
| featValid | input | 1 | Qualifies `featIn` |
| featIn | input | 9 | Serial input feature, signed 2.7 |
| weights | input | NEUR*FEAT*9 | Packed weights, neuron-major |
| biases | input | NEUR*9 | Packed biases, one per neuron |
| actValid | output | 1 | Qualifies `actOut` |
| actOut | output | 9 | Serial activation, signed 2.7 |
| layerDone | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench targets these cases:
- **Narrowing and saturation.** Large positive and large negative sums are driven. A design that wrapped instead of saturating, or that rounded instead of shifting, would give activations from the wrong end of the table.
- **Gaps in the feature stream.** Idle cycles are inserted between features. A design that counted cycles instead of valid features would mix in stale inputs.
- **A second start pulse and stray features during a run.** Both are injected mid-run. A design that restarted on either would lose outputs, shift the latency or pulse done twice.
- **Timing and order.** Output order, latency and done position are checked against edge counts. An extra or missing pipeline stage, or a reversed shift direction, shows up as a latency error or as neuron values in the wrong slots.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  // Strobes from control to datapath, one bit per action
  typedef struct packed {
    logic clearAcc;   // preload accumulators with bias
    logic macEn;      // accumulate the current feature
    logic loadPiso;   // capture all narrowed sums
    logic shiftOut;   // emit PISO head into the sigmoid table
  } fclStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCUM,
    ST_LOAD,
    ST_SHIFT,
    ST_DRAIN,
    ST_DONE
  } fclState_t;

endpackage

// File: rtl/fcl_sigmoid_rom.sv
module fcl_sigmoid_rom #(
  parameter int DW = 9,
  parameter int FW = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rd,
  input  logic signed [DW-1:0] addr,
  output logic                 valid,
  output logic signed [DW-1:0] data
);

  localparam int DEPTH = 1 << DW;
  localparam int SHIFT_S = 20;

  // Fixed-point sigmoid built from a fifth-order exponential series
  function automatic int sigVal(input int a);
    longint scale;
    longint t;
    longint term;
    longint e;
    longint num;
    longint den;
    scale = longint'(1) << SHIFT_S;
    t = longint'(a < 0 ? -a : a) << (SHIFT_S - FW);
    term = scale;
    e = scale;
    for (int k = 1; k <= 5; k++) begin
      term = (term * t) / (longint'(k) * scale);
      e = e + term;
    end
    num = (a >= 0) ? e : scale;
    den = scale + e;
    return int'((num * (longint'(1) << FW) + den / 2) / den);
  endfunction

  logic signed [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(sigVal(i >= DEPTH / 2 ? i - DEPTH : i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) valid <= 1'b0;
    else       valid <= rd;
  end

  always_ff @(posedge clk) begin
    if (rd) data <= mem[$unsigned(addr)];
  end

endmodule

// File: rtl/fcl_datapath.sv
module fcl_datapath
  import fcl_pkg::*;
#(
  parameter int NEUR = 4,
  parameter int FEAT = 6,
  parameter int DW   = 9,
  parameter int FW   = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fclStrobes_t                strobes,
  input  logic [$clog2(FEAT)-1:0]    featIdx,
  input  logic signed [DW-1:0]       featIn,
  input  logic [NEUR*FEAT*DW-1:0]    weights,
  input  logic [NEUR*DW-1:0]         biases,
  output logic                       actValid,
  output logic signed [DW-1:0]       actOut
);

  localparam int ACCW = 2 * DW + $clog2(FEAT) + 2;
  localparam logic signed [ACCW-1:0] SAT_HI = ACCW'((1 << (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] SAT_LO = ACCW'(-(1 << (DW - 1)));

  function automatic logic signed [DW-1:0] narrow(input logic signed [ACCW-1:0] v);
    logic signed [ACCW-1:0] sh;
    sh = v >>> FW;
    if (sh > SAT_HI)      return SAT_HI[DW-1:0];
    else if (sh < SAT_LO) return SAT_LO[DW-1:0];
    else                  return sh[DW-1:0];
  endfunction

  logic signed [DW-1:0] narrowed [NEUR];
  logic signed [DW-1:0] piso     [NEUR];

  // One iterative MAC per neuron
  for (genvar n = 0; n < NEUR; n++) begin : g_mac
    logic signed [DW-1:0]   wSel;
    logic signed [DW-1:0]   bSel;
    logic signed [2*DW-1:0] prod;
    logic signed [ACCW-1:0] acc;

    assign wSel = $signed(weights[(n * FEAT + int'(featIdx)) * DW +: DW]);
    assign bSel = $signed(biases[n * DW +: DW]);
    assign prod = wSel * featIn;

    always_ff @(posedge clk) begin
      if (!rstN)                 acc <= '0;
      else if (strobes.clearAcc) acc <= ACCW'(bSel) <<< FW;
      else if (strobes.macEn)    acc <= acc + ACCW'(prod);
    end

    assign narrowed[n] = narrow(acc);
  end

  // Parallel-in serial-out register, head at index 0
  for (genvar i = 0; i < NEUR; i++) begin : g_piso
    always_ff @(posedge clk) begin
      if (!rstN) begin
        piso[i] <= '0;
      end else if (strobes.loadPiso) begin
        piso[i] <= narrowed[i];
      end else if (strobes.shiftOut) begin
        if (i == NEUR - 1) piso[i] <= '0;
        else               piso[i] <= piso[(i + 1) % NEUR];
      end
    end
  end

  fcl_sigmoid_rom #(.DW(DW), .FW(FW)) u_rom (
    .clk   (clk),
    .rstN  (rstN),
    .rd    (strobes.shiftOut),
    .addr  (piso[0]),
    .valid (actValid),
    .data  (actOut)
  );

endmodule

// File: rtl/fcl_ctrl.sv
module fcl_ctrl
  import fcl_pkg::*;
#(
  parameter int NEUR = 4,
  parameter int FEAT = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    layerInit,
  input  logic                    featValid,
  output fclStrobes_t             strobes,
  output logic [$clog2(FEAT)-1:0] featIdx,
  output logic                    busy,
  output logic                    layerDone
);

  localparam int IW = $clog2(FEAT);
  localparam int OW = $clog2(NEUR);
  localparam logic [IW-1:0] LAST_FEAT = IW'(FEAT - 1);
  localparam logic [OW-1:0] LAST_NEUR = OW'(NEUR - 1);

  fclState_t     state;
  logic [IW-1:0] featCnt;
  logic [OW-1:0] outCnt;

  always_comb begin
    strobes   = '0;
    featIdx   = featCnt;
    busy      = (state != ST_IDLE);
    layerDone = (state == ST_DONE);
    case (state)
      ST_IDLE:  strobes.clearAcc = layerInit;
      ST_ACCUM: strobes.macEn    = featValid;
      ST_LOAD:  strobes.loadPiso = 1'b1;
      ST_SHIFT: strobes.shiftOut = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      featCnt <= '0;
      outCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          featCnt <= '0;
          if (layerInit) state <= ST_ACCUM;
        end
        ST_ACCUM: begin
          if (featValid) begin
            if (featCnt == LAST_FEAT) begin
              state   <= ST_LOAD;
              featCnt <= '0;
            end else begin
              featCnt <= featCnt + 1'b1;
            end
          end
        end
        ST_LOAD: begin
          outCnt <= '0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (outCnt == LAST_NEUR) state  <= ST_DRAIN;
          else                     outCnt <= outCnt + 1'b1;
        end
        ST_DRAIN: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fc_serial_layer.sv
module fc_serial_layer
  import fcl_pkg::*;
#(
  parameter int NEUR = 4,
  parameter int FEAT = 6,
  parameter int DW   = 9,
  parameter int FW   = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    layerInit,
  input  logic                    featValid,
  input  logic signed [DW-1:0]    featIn,
  input  logic [NEUR*FEAT*DW-1:0] weights,
  input  logic [NEUR*DW-1:0]      biases,
  output logic                    actValid,
  output logic signed [DW-1:0]    actOut,
  output logic                    layerDone
);

  fclStrobes_t             strobes;
  logic [$clog2(FEAT)-1:0] featIdx;
  logic                    busy;

  fcl_ctrl #(.NEUR(NEUR), .FEAT(FEAT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .layerInit (layerInit),
    .featValid (featValid),
    .strobes   (strobes),
    .featIdx   (featIdx),
    .busy      (busy),
    .layerDone (layerDone)
  );

  fcl_datapath #(.NEUR(NEUR), .FEAT(FEAT), .DW(DW), .FW(FW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .featIdx  (featIdx),
    .featIn   (featIn),
    .weights  (weights),
    .biases   (biases),
    .actValid (actValid),
    .actOut   (actOut)
  );

endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
  parameter int NEUR = 4,
  parameter int DW   = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busy,
  input logic                 actValid,
  input logic signed [DW-1:0] actOut,
  input logic                 layerDone
);

  localparam int CW = $clog2(NEUR + 1) + 1;
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rstN)          seen <= '0;
    else if (layerDone) seen <= '0;
    else if (actValid)  seen <= seen + 1'b1;
  end

  // R7: done lasts a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    layerDone |=> !layerDone);

  // R7: done follows directly on the last valid output
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    layerDone |-> $past(actValid));

  // R5: exactly NEUR outputs per run
  assert_out_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    layerDone |-> (seen == CW'(NEUR)));

  // R5: outputs are back to back, the stream ends only into done
  assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(actValid) |-> layerDone);

  // R1: outputs only while a run is in progress
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !actValid);

  // R4: sigmoid output stays strictly inside (0, 1)
  assert_act_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    actValid |-> (actOut > 0 && actOut < (1 <<< (DW - 2))));

endmodule

bind fc_serial_layer fcl_checker #(.NEUR(NEUR), .DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .actValid  (actValid),
  .actOut    (actOut),
  .layerDone (layerDone)
);

// File: tb/fc_serial_layer_tb.sv
module fc_serial_layer_tb;

  localparam int NEUR = 4;
  localparam int FEAT = 6;
  localparam int DW   = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic layerInit = 1'b0;
  logic featValid = 1'b0;
  logic signed [DW-1:0] featIn = '0;
  logic [NEUR*FEAT*DW-1:0] weights = '0;
  logic [NEUR*DW-1:0] biases = '0;
  logic actValid;
  logic signed [DW-1:0] actOut;
  logic layerDone;

  always #2.5 clk = ~clk;

  fc_serial_layer #(.NEUR(NEUR), .FEAT(FEAT), .DW(DW), .FW(7)) u_dut (
    .clk(clk), .rstN(rstN), .layerInit(layerInit), .featValid(featValid),
    .featIn(featIn), .weights(weights), .biases(biases),
    .actValid(actValid), .actOut(actOut), .layerDone(layerDone)
  );

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  bit finished = 0;

  int tw [NEUR][FEAT];
  int tbias [NEUR];
  int tx [FEAT];

  int obsAct [16];
  int obsEdge [16];
  int nObs = 0;
  int doneEdge = 0;
  int doneCnt = 0;
  int baseEdge = 0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (actValid) begin
        if (nObs < 16) begin
          obsAct[nObs] = int'(actOut);
          obsEdge[nObs] = edgeCnt;
        end
        nObs = nObs + 1;
      end
      if (layerDone) begin
        doneEdge = edgeCnt;
        doneCnt = doneCnt + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkNear(input string req, input string what, input int act, input int exp);
    checks++;
    if (act > exp + 1 || act < exp - 1) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sigExp(input int a);
    real z;
    real e;
    real term;
    real s;
    z = (a < 0 ? -a : a) / 128.0;
    e = 1.0;
    term = 1.0;
    for (int k = 1; k <= 5; k++) begin
      term = term * z / k;
      e = e + term;
    end
    s = (a >= 0) ? e / (1.0 + e) : 1.0 / (1.0 + e);
    return $rtoi(s * 128.0 + 0.5);
  endfunction

  // R2 and R3: narrowed pre-activation value
  function automatic int narrowExp(input int n);
    int sum;
    int sh;
    sum = tbias[n] * 128;
    for (int j = 0; j < FEAT; j++) sum = sum + tw[n][j] * tx[j];
    sh = sum >>> 7;
    if (sh > 255) sh = 255;
    if (sh < -256) sh = -256;
    return sh;
  endfunction

  task automatic packParams();
    for (int n = 0; n < NEUR; n++) begin
      biases[n*DW +: DW] = DW'(tbias[n]);
      for (int j = 0; j < FEAT; j++) weights[(n*FEAT + j)*DW +: DW] = DW'(tw[n][j]);
    end
  endtask

  // gapCycles idle cycles before each feature; noisy injects a busy init and stray features
  task automatic runStream(input int gapCycles, input bit noisy);
    packParams();
    @(negedge clk);
    nObs = 0;
    doneCnt = 0;
    baseEdge = edgeCnt + 1;
    layerInit = 1'b1;
    @(negedge clk);
    layerInit = 1'b0;
    for (int j = 0; j < FEAT; j++) begin
      for (int g = 0; g < gapCycles; g++) begin
        featValid = 1'b0;
        featIn = DW'(-77);
        @(negedge clk);
      end
      featValid = 1'b1;
      featIn = DW'(tx[j]);
      layerInit = noisy && (j == 2);
      @(negedge clk);
    end
    layerInit = 1'b0;
    featValid = noisy;
    featIn = DW'(200);
    for (int c = 0; c < NEUR + 6; c++) begin
      layerInit = noisy && (c == 3);
      @(negedge clk);
    end
    layerInit = 1'b0;
    featValid = 1'b0;
    featIn = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkRun(input string tag, input bit checkLatency);
    check("R5", {tag, " output count"}, nObs, NEUR);
    for (int n = 0; n < NEUR && n < nObs; n++) begin
      checkNear("R4", $sformatf("%s neuron %0d value", tag, n), obsAct[n], sigExp(narrowExp(n)));
      if (n > 0) check("R5", $sformatf("%s neuron %0d back to back", tag, n), obsEdge[n], obsEdge[n-1] + 1);
    end
    if (checkLatency && nObs > 0)
      check("R6", {tag, " first output edge"}, obsEdge[0] - baseEdge, FEAT + 2);
    check("R7", {tag, " done pulse count"}, doneCnt, 1);
    if (nObs > 0 && nObs <= 16)
      check("R7", {tag, " done after last"}, doneEdge, obsEdge[nObs-1] + 1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "actValid after reset", int'(actValid), 0);
    check("R1", "layerDone after reset", int'(layerDone), 0);
    check("R1", "no outputs while idle", nObs, 0);
  endtask

  task automatic testBasic();
    for (int n = 0; n < NEUR; n++) begin
      tbias[n] = (n - 2) * 20;
      for (int j = 0; j < FEAT; j++) tw[n][j] = ((n * 7 + j * 13) % 61) - 30 + n * 10;
    end
    for (int j = 0; j < FEAT; j++) tx[j] = (j * 37) % 200 - 90;
    runStream(0, 1'b0);
    checkRun("basic", 1'b1);
  endtask

  task automatic testOrder();
    // distinct biases only: ascending neuron order gives ascending outputs (R5)
    for (int n = 0; n < NEUR; n++) begin
      tbias[n] = -180 + n * 110;
      for (int j = 0; j < FEAT; j++) tw[n][j] = 0;
    end
    for (int j = 0; j < FEAT; j++) tx[j] = 100;
    runStream(0, 1'b0);
    checkRun("order", 1'b1);
    for (int n = 1; n < NEUR && n < nObs; n++)
      check("R5", $sformatf("ascending slot %0d", n), int'(obsAct[n] > obsAct[n-1]), 1);
  endtask

  task automatic testSaturate();
    for (int n = 0; n < NEUR; n++) begin
      tbias[n] = (n % 2 == 0) ? 255 : -256;
      for (int j = 0; j < FEAT; j++) tw[n][j] = (n % 2 == 0) ? 255 : -256;
    end
    for (int j = 0; j < FEAT; j++) tx[j] = 255;
    runStream(0, 1'b0);
    check("R3", "positive saturation", narrowExp(0), 255);
    check("R3", "negative saturation", narrowExp(1), -256);
    checkRun("saturate", 1'b1);
  endtask

  task automatic testZero();
    for (int n = 0; n < NEUR; n++) begin
      tbias[n] = 0;
      for (int j = 0; j < FEAT; j++) tw[n][j] = 0;
    end
    for (int j = 0; j < FEAT; j++) tx[j] = 123;
    runStream(0, 1'b0);
    checkRun("zero", 1'b1);
    if (nObs > 0) check("R4", "sigmoid of zero", obsAct[0], 64);
  endtask

  task automatic testGaps();
    for (int n = 0; n < NEUR; n++) begin
      tbias[n] = 5 - n * 3;
      for (int j = 0; j < FEAT; j++) tw[n][j] = 40 - j * 9 + n * 5;
    end
    for (int j = 0; j < FEAT; j++) tx[j] = 60 - j * 25;
    runStream(2, 1'b0);
    checkRun("gaps R2", 1'b0);
  endtask

  task automatic testBusyInit();
    for (int n = 0; n < NEUR; n++) begin
      tbias[n] = n * 15 - 20;
      for (int j = 0; j < FEAT; j++) tw[n][j] = (j % 2 == 0) ? 50 + n : -30 - n;
    end
    for (int j = 0; j < FEAT; j++) tx[j] = 90 - j * 11;
    runStream(0, 1'b1);
    checkRun("busy init R8", 1'b1);
  endtask

  task automatic testBackToBack();
    // R9: second run right after the first reflects only its own features
    for (int n = 0; n < NEUR; n++) begin
      tbias[n] = 10;
      for (int j = 0; j < FEAT; j++) tw[n][j] = 100;
    end
    for (int j = 0; j < FEAT; j++) tx[j] = 120;
    runStream(0, 1'b0);
    checkRun("first of pair R9", 1'b1);
    for (int j = 0; j < FEAT; j++) tx[j] = -60;
    runStream(0, 1'b0);
    checkRun("second of pair R9", 1'b1);
  endtask

  initial begin
    testReset();
    testBasic();
    testOrder();
    testSaturate();
    testZero();
    testGaps();
    testBusyInit();
    testBackToBack();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule